// File: doc/BRIEF.md
# Cascadable presettable binary counter

A chain of identical 4-bit synchronous up-counter stages. Each stage can take a parallel word or increment, and it raises a terminal-count flag when it sits at its top value while its trickle enable is high. That flag drives the trickle enable of the next stage. With a shared clock, a shared load strobe and a shared parallel-count enable, the chain counts as one wide binary counter.

Each stage has two count enables, and they do different jobs. The parallel enable only gates counting. The trickle enable gates counting and also the terminal-count flag, which is what carries the increment from one stage to the next. Load overrides both enables. A parameter sets the clear mode. In asynchronous mode the clear acts at once, without waiting for a clock edge. In synchronous mode it acts at the next rising edge, which means a decode of the count fed back into the clear shortens the counting modulus.

Top module: `cnt_chain`

## Requirements
- R1: When load_ni is low at a rising edge of clk_i, every stage copies its slice of data_i into count_o at that edge, whatever the levels of cnt_par_i and cnt_tri_i. Stage k uses bits [4k+3:4k] of data_i and count_o.
- R2: With load_ni high and clear inactive, a stage increments at a rising edge only when its parallel enable and its trickle enable are both high. It wraps from 15 to 0.
- R3: With load_ni high, clear inactive and the two enables not both high, the count holds its value across the edge.
- R4: In asynchronous clear mode (CLR_MODE = CLR_ASYNC), rst_ni low forces count_o to zero at once, with no clock edge and regardless of load and enables.
- R5: In synchronous clear mode (CLR_MODE = CLR_SYNC), rst_ni low leaves count_o unchanged until the next rising edge. It then zeroes the count, taking priority over load and count.
- R6: A stage's terminal-count flag is 1 exactly when its trickle enable is 1 and its count is all ones. tc_o is the flag of the last stage.
- R7: The trickle enable of stage 0 is cnt_tri_i, and the trickle enable of stage k is the flag of stage k-1. The chain therefore counts as one N_STAGES*4-bit binary counter, and tc_o is 1 exactly when cnt_tri_i is 1 and count_o is all ones.
- R8: A single stage in synchronous clear mode, with rst_ni driven low by a decode of count 9, counts 0,1,...,9,0 (modulo 10) and never raises its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low clear, asynchronous or synchronous according to CLR_MODE |
| load_ni | input | 1 | Active-low parallel load strobe, shared by all stages |
| cnt_par_i | input | 1 | Parallel count enable, shared by all stages |
| cnt_tri_i | input | 1 | Trickle count enable of stage 0 |
| data_i | input | N_STAGES*STAGE_W | Parallel load word |
| count_o | output | N_STAGES*STAGE_W | Chained count, stage 0 in the low bits |
| tc_o | output | 1 | Terminal-count flag of the last stage |

## Verification
Load, increment, hold and synchronous clear all show on count_o one rising edge after their inputs. The terminal-count flag follows combinationally from the registered count and the current trickle enable. The bench changes inputs on a falling edge and compares against its arithmetic reference at the next falling edge, half a cycle after the edge that produced the result. Asynchronous clear is the exception: the bench checks it 1 ns after driving rst_ni low, before any edge, and checks the synchronous-mode chain at that same moment to show its count has not yet moved. The modulo-10 stage feeds back through combinational decode, so the bench checks each of its states at every falling edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic {
    CLR_ASYNC = 1'b0,
    CLR_SYNC  = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/cnt_tc.sv
module cnt_tc #(
  parameter int W = 4
) (
  input  logic [W-1:0] cnt_i,
  input  logic         en_i,
  output logic         tc_o
);
  assign tc_o = en_i & (&cnt_i);
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int        W        = 4,
  parameter clr_mode_e CLR_MODE = CLR_ASYNC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic         cnt_par_i,
  input  logic         cnt_tri_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o,
  output logic         tc_o
);
  logic [W-1:0] q, q_nxt;

  always_comb begin
    q_nxt = q;
    if (!load_ni)                     q_nxt = data_i;
    else if (cnt_par_i && cnt_tri_i)  q_nxt = q + 1'b1;
  end

  generate
    if (CLR_MODE == CLR_SYNC) begin : g_sync_clr
      always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= q_nxt;
      end

      // R5
      sync_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> (q == '0));
    end else begin : g_async_clr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= q_nxt;
      end
    end
  endgenerate

  cnt_tc #(.W(W)) i_tc (
    .cnt_i (q),
    .en_i  (cnt_tri_i),
    .tc_o  (tc_o)
  );

  assign count_o = q;

  // R1
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> (q == $past(data_i)));

  // R2
  incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_par_i && cnt_tri_i) |=> (q == $past(q) + 1'b1));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(cnt_par_i && cnt_tri_i)) |=> $stable(q));

  // R6
  tc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> cnt_tri_i);
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
  import cnt_pkg::*;
#(
  parameter int        N_STAGES = 3,
  parameter int        STAGE_W  = 4,
  parameter clr_mode_e CLR_MODE = CLR_ASYNC
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_ni,
  input  logic                        cnt_par_i,
  input  logic                        cnt_tri_i,
  input  logic [N_STAGES*STAGE_W-1:0] data_i,
  output logic [N_STAGES*STAGE_W-1:0] count_o,
  output logic                        tc_o
);
  localparam int CW = N_STAGES * STAGE_W;

  logic [N_STAGES:0] tri_chain;

  // R7: each stage's flag feeds the next stage's trickle enable
  assign tri_chain[0] = cnt_tri_i;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    cnt_stage #(
      .W        (STAGE_W),
      .CLR_MODE (CLR_MODE)
    ) i_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_ni   (load_ni),
      .cnt_par_i (cnt_par_i),
      .cnt_tri_i (tri_chain[k]),
      .data_i    (data_i[k*STAGE_W +: STAGE_W]),
      .count_o   (count_o[k*STAGE_W +: STAGE_W]),
      .tc_o      (tri_chain[k+1])
    );
  end

  assign tc_o = tri_chain[N_STAGES];

  // R7
  chain_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (count_o == {CW{1'b1}}));

  // R7
  chain_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_par_i && cnt_tri_i) |=> (count_o == $past(count_o) + 1'b1));
endmodule

// File: tb/test_cnt_chain.sv
module test_cnt_chain;
  import cnt_pkg::*;

  localparam int NS = 3;
  localparam int SW = 4;
  localparam int CW = NS * SW;

  logic          clk = 1'b0;
  logic          rst_a_n, rst_s_n, load_n, par, trk;
  logic [CW-1:0] data;
  logic [CW-1:0] cnt_a, cnt_s;
  logic          tc_a, tc_s;

  logic          mod_clr_n, mod_en, mod_rst_n, mod_tc;
  logic [SW-1:0] mod_cnt;

  int total = 0;
  int bad   = 0;
  logic [CW-1:0] ea = '0, es = '0;
  logic [SW-1:0] em = '0;

  always #5 clk = ~clk;

  cnt_chain #(.N_STAGES(NS), .STAGE_W(SW), .CLR_MODE(CLR_ASYNC)) i_cnt_chain (
    .clk_i(clk), .rst_ni(rst_a_n), .load_ni(load_n), .cnt_par_i(par),
    .cnt_tri_i(trk), .data_i(data), .count_o(cnt_a), .tc_o(tc_a));

  cnt_chain #(.N_STAGES(NS), .STAGE_W(SW), .CLR_MODE(CLR_SYNC)) i_cnt_chain_sync (
    .clk_i(clk), .rst_ni(rst_s_n), .load_ni(load_n), .cnt_par_i(par),
    .cnt_tri_i(trk), .data_i(data), .count_o(cnt_s), .tc_o(tc_s));

  // R8: modulus set by decoding count 9 into the synchronous clear
  assign mod_rst_n = mod_clr_n & (mod_cnt != 4'd9);

  cnt_chain #(.N_STAGES(1), .STAGE_W(SW), .CLR_MODE(CLR_SYNC)) i_cnt_chain_mod (
    .clk_i(clk), .rst_ni(mod_rst_n), .load_ni(1'b1), .cnt_par_i(mod_en),
    .cnt_tri_i(mod_en), .data_i('0), .count_o(mod_cnt), .tc_o(mod_tc));

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // inputs change on a falling edge; results compared on the next falling edge
  task automatic step(input logic ld_n, input logic p, input logic t,
                      input logic [CW-1:0] d, input logic ra_n, input logic rs_n,
                      input string req);
    logic [CW-1:0] s_before;
    s_before = cnt_s;
    load_n = ld_n; par = p; trk = t; data = d; rst_a_n = ra_n; rst_s_n = rs_n;
    if (!ra_n || !rs_n) begin
      #1;
      if (!ra_n) chk("R4 async clear before edge", cnt_a, '0);
      if (!rs_n) chk("R5 sync clear waits for edge", cnt_s, s_before);
    end
    @(posedge clk);
    @(negedge clk);
    if (!ra_n) ea = '0; else if (!ld_n) ea = d; else if (p && t) ea = ea + 1'b1;
    if (!rs_n) es = '0; else if (!ld_n) es = d; else if (p && t) es = es + 1'b1;
    chk(req, cnt_a, ea);
    chk(req, cnt_s, es);
    chk({req, " R6 tc"}, {{(CW-1){1'b0}}, tc_a}, {{(CW-1){1'b0}}, (t && ea == {CW{1'b1}})});
    chk({req, " R6 tc"}, {{(CW-1){1'b0}}, tc_s}, {{(CW-1){1'b0}}, (t && es == {CW{1'b1}})});
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_a_n = 1'b0; rst_s_n = 1'b0; load_n = 1'b1; par = 1'b0; trk = 1'b0; data = '0;
    mod_clr_n = 1'b0; mod_en = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R4 reset state", cnt_a, '0);
    chk("R5 reset state", cnt_s, '0);

    // R1: load while both enables low, and while both high
    step(1'b0, 1'b0, 1'b0, 12'hFFE, 1'b1, 1'b1, "R1 load disabled");
    step(1'b0, 1'b1, 1'b1, 12'h0EF, 1'b1, 1'b1, "R1 load over count");
    // R2/R7: carry across stages
    step(1'b1, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R7 carry into stage1");
    // R3: only one enable high
    step(1'b1, 1'b0, 1'b1, '0, 1'b1, 1'b1, "R3 par low hold");
    step(1'b1, 1'b1, 1'b0, '0, 1'b1, 1'b1, "R3 tri low hold");
    // R2/R6/R7: full sweep through all-ones and the wrap
    step(1'b0, 1'b0, 1'b0, 12'hFF0, 1'b1, 1'b1, "R1 preload");
    for (int i = 0; i < 4200; i++) step(1'b1, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R2 R7 sweep");
    // tc gated by trickle enable at all-ones
    step(1'b0, 1'b0, 1'b1, 12'hFFF, 1'b1, 1'b1, "R6 load all ones");
    step(1'b1, 1'b1, 1'b0, '0, 1'b1, 1'b1, "R6 tri low at all ones");
    step(1'b1, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R2 wrap to zero");
    // mixed enables with occasional loads
    for (int i = 0; i < 600; i++)
      step((i % 97 == 50) ? 1'b0 : 1'b1, (i % 5 != 0), (i % 7 != 3),
           12'(i * 37 + 5), 1'b1, 1'b1, "R3 R7 mixed");
    // R4: async clear mid-count, held across an edge with load active
    step(1'b1, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R2 before clear");
    step(1'b0, 1'b1, 1'b1, 12'h5A5, 1'b0, 1'b1, "R4 async clear");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R2 after clear");
    // R5: sync clear mid-count beats load and count
    step(1'b0, 1'b1, 1'b1, 12'h3C3, 1'b1, 1'b0, "R5 sync clear over load");
    step(1'b1, 1'b1, 1'b1, '0, 1'b1, 1'b0, "R5 sync clear over count");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R2 after sync clear");
    // both clears together while loading
    step(1'b0, 1'b0, 1'b0, 12'h777, 1'b0, 1'b0, "R4 R5 both clears");
    step(1'b1, 1'b1, 1'b1, '0, 1'b1, 1'b1, "R2 resume");

    // R8: modulo-10 stage
    @(negedge clk);
    chk("R8 mod reset", {8'h0, mod_cnt}, '0);
    mod_clr_n = 1'b1; mod_en = 1'b1; em = '0;
    for (int i = 0; i < 35; i++) begin
      @(posedge clk); @(negedge clk);
      em = (em == 4'd9) ? 4'd0 : em + 4'd1;
      chk("R8 mod10 count", {8'h0, mod_cnt}, {8'h0, em});
      chk("R8 mod10 no tc", {11'h0, mod_tc}, '0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule